// File: doc/BRIEF.md
# Load-Switch Fault Sequencer

This block controls the series switch of a charger port's supply rail. It takes comparator results that are already synchronized and deglitched: input below the undervoltage level, input above the overvoltage level, input back below the overvoltage level minus its hysteresis, die above the thermal trip point, and die below the cool-down point. It also takes an enable input. From these it drives a gate-enable for the switch and an acknowledge flag that reports power is delivered.

Any fault opens the switch on the next clock edge. Closing the switch always needs a qualification period in which the input stays good. The length of that period depends on why the switch opened. A cold start, an undervoltage, or a fresh enable uses the long delay. A pure overvoltage event uses the short delay. A thermal trip uses hysteresis instead of a timer. Both delays are counted in ticks of a millisecond prescaler, so a test can shorten them by changing parameters.

Top module: `load_switch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `gateOn` and `ackOut` are 0 on the next edge, and the fault memory is cleared.
- R2: With `enIn`=1, `uvFlag`=0, `ovFlag`=0, `hotTrip`=0 and no overvoltage memory, `gateOn` rises exactly LONG_MS*TICK_DIV+1 edges after the first edge that sees these conditions, provided they hold without a break.
- R3: `uvFlag`=1 or `ovFlag`=1 at an edge drives `gateOn` to 0 at that edge.
- R4: After the switch opens because of `ovFlag`, requalification starts only when `ovClrFlag`=1 and `ovFlag`=0. It then lasts SHORT_MS*TICK_DIV+1 edges. If `ovClrFlag`=0 while `ovFlag`=0, the switch stays open.
- R5: An undervoltage event, or an enable drop, clears the overvoltage memory, so the next closure uses the long delay of R2.
- R6: `hotTrip`=1 at an edge opens the switch. It stays open until an edge with `hotTrip`=0 and `coolOk`=1.
- R7: At that thermal exit edge the switch closes at once if `enIn`=1, `uvFlag`=0 and `ovFlag`=0. Otherwise it reopens through the qualification of R2 or R4.
- R8: `ackOut` equals `gateOn` on every cycle.
- R9: Any fault or enable drop during a pending qualification aborts it. A later qualification counts from zero.
- R10: `enIn`=0 at an edge opens the switch at that edge.
- R11: Priority at an edge, highest first: thermal trip, enable low, undervoltage, overvoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enIn | input | 1 | Switch enable request |
| uvFlag | input | 1 | 1 = input below the undervoltage level |
| ovFlag | input | 1 | 1 = input above the overvoltage level |
| ovClrFlag | input | 1 | 1 = input below overvoltage level minus hysteresis |
| hotTrip | input | 1 | 1 = die above the thermal trip point |
| coolOk | input | 1 | 1 = die below the cool-down point |
| gateOn | output | 1 | Switch gate enable |
| ackOut | output | 1 | Power-delivered acknowledge |

## Verification
The hardest situations to reach are a fault that lands one cycle before a qualification completes, and the hysteresis band in which `ovFlag` and `ovClrFlag` are both 0. The bench shortens the millisecond tick to ten clocks. It pulses faults in the middle of running counts and holds the band for many cycles. A behavioural per-cycle model predicts the exact closing edge, and any off-by-one in the restart shows up as a mismatch. Thermal exits are driven with the rail good, with it undervolted, and with enable low.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_QLONG  = 3'd1,
    ST_QSHORT = 3'd2,
    ST_ON     = 3'd3,
    ST_THERM  = 3'd4
  } lssState_t;

  typedef struct packed {
    logic clr;
    logic run;
    logic useShort;
  } lssStrobe_t;
endpackage

// File: rtl/lss_timer.sv
module lss_timer
  import lss_pkg::*;
#(
  parameter int TICK_DIV = 50000,
  parameter int LONG_MS  = 16,
  parameter int SHORT_MS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  lssStrobe_t strb,
  output logic       done
);
  localparam int MAX_MS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
  localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MS_W   = $clog2(MAX_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [MS_W-1:0]  LONG_T   = MS_W'(LONG_MS);
  localparam logic [MS_W-1:0]  SHORT_T  = MS_W'(SHORT_MS);
  localparam logic [MS_W-1:0]  MAX_T    = MS_W'(MAX_MS);

  logic [PRE_W-1:0] preCnt;
  logic [MS_W-1:0]  msCnt;
  logic [MS_W-1:0]  target;

  assign target = strb.useShort ? SHORT_T : LONG_T;
  assign done   = (msCnt == target);

  always_ff @(posedge clk) begin
    if (rst || strb.clr) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (strb.run && !done) begin
      if (preCnt == PRE_LAST) begin
        preCnt <= '0;
        msCnt  <= msCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R9
  ms_bound_chk: assert property (@(posedge clk) disable iff (rst)
    msCnt <= MAX_T);

  // R9
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clr |=> (msCnt == '0));
endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl
  import lss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enIn,
  input  logic       uvFlag,
  input  logic       ovFlag,
  input  logic       ovClrFlag,
  input  logic       hotTrip,
  input  logic       coolOk,
  input  logic       tmrDone,
  output lssStrobe_t strb,
  output logic       gateOn,
  output logic       ackOut
);
  lssState_t state, nState;
  logic      faultOv, nFaultOv;
  logic      gateQ;

  always_comb begin
    nState   = state;
    nFaultOv = faultOv;
    if (hotTrip) begin
      nState = ST_THERM;
    end else if (state == ST_THERM) begin
      if (coolOk) nState = (enIn && !uvFlag && !ovFlag) ? ST_ON : ST_OFF;
    end else if (!enIn || uvFlag) begin
      nState   = ST_OFF;
      nFaultOv = 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          if (faultOv) begin
            if (ovClrFlag && !ovFlag) nState = ST_QSHORT;
          end else if (!ovFlag) begin
            nState = ST_QLONG;
          end
        end
        ST_QLONG: begin
          if (ovFlag) begin
            nState   = ST_OFF;
            nFaultOv = 1'b1;
          end else if (tmrDone) begin
            nState = ST_ON;
          end
        end
        ST_QSHORT: begin
          if (ovFlag || !ovClrFlag) nState = ST_OFF;
          else if (tmrDone)         nState = ST_ON;
        end
        ST_ON: begin
          if (ovFlag) begin
            nState   = ST_OFF;
            nFaultOv = 1'b1;
          end
        end
        default: nState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OFF;
      faultOv <= 1'b0;
      gateQ   <= 1'b0;
    end else begin
      state   <= nState;
      faultOv <= nFaultOv;
      gateQ   <= (nState == ST_ON);
    end
  end

  always_comb begin
    strb.run      = (state == ST_QLONG) || (state == ST_QSHORT);
    strb.clr      = !strb.run;
    strb.useShort = (state == ST_QSHORT);
  end

  assign gateOn = gateQ;
  assign ackOut = gateQ;

  // R3
  uv_open_chk: assert property (@(posedge clk) disable iff (rst)
    uvFlag |=> !gateOn);

  // R6
  trip_open_chk: assert property (@(posedge clk) disable iff (rst)
    hotTrip |=> !gateOn);

  // R10
  en_open_chk: assert property (@(posedge clk) disable iff (rst)
    !enIn |=> !gateOn);

  // R4
  short_needs_ov_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_QSHORT) |-> faultOv);

  // R2
  close_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gateOn) |-> ($past(state) == ST_THERM || $past(tmrDone)));
endmodule

// File: rtl/load_switch_seq.sv
module load_switch_seq
  import lss_pkg::*;
#(
  parameter int TICK_DIV = 50000,
  parameter int LONG_MS  = 16,
  parameter int SHORT_MS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enIn,
  input  logic uvFlag,
  input  logic ovFlag,
  input  logic ovClrFlag,
  input  logic hotTrip,
  input  logic coolOk,
  output logic gateOn,
  output logic ackOut
);
  lssStrobe_t strb;
  logic       tmrDone;

  lss_ctrl ctrl_i (
    .clk(clk), .rst(rst), .enIn(enIn), .uvFlag(uvFlag), .ovFlag(ovFlag),
    .ovClrFlag(ovClrFlag), .hotTrip(hotTrip), .coolOk(coolOk),
    .tmrDone(tmrDone), .strb(strb), .gateOn(gateOn), .ackOut(ackOut)
  );

  lss_timer #(
    .TICK_DIV(TICK_DIV), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)
  ) timer_i (
    .clk(clk), .rst(rst), .strb(strb), .done(tmrDone)
  );
endmodule

// File: tb/load_switch_seq_tb_top.sv
module load_switch_seq_tb_top;
  localparam int D = 10;
  localparam int L = 16;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enIn = 1'b0, uvFlag = 1'b1, ovFlag = 1'b0, ovClrFlag = 1'b1;
  logic hotTrip = 1'b0, coolOk = 1'b1;
  logic gateOn, ackOut;

  always #5 clk = ~clk;

  load_switch_seq #(.TICK_DIV(D), .LONG_MS(L), .SHORT_MS(S)) dut_i (
    .clk(clk), .rst(rst), .enIn(enIn), .uvFlag(uvFlag), .ovFlag(ovFlag),
    .ovClrFlag(ovClrFlag), .hotTrip(hotTrip), .coolOk(coolOk),
    .gateOn(gateOn), .ackOut(ackOut)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  // behavioural reference: switch state, thermal hold, ov memory, elapsed qualification cycles
  bit mOn = 1'b0, mTherm = 1'b0, mOvMem = 1'b0;
  int mCnt = -1;
  int mNeed = 0;

  always @(posedge clk) begin
    if (rst) begin
      mOn = 0; mTherm = 0; mOvMem = 0; mCnt = -1;
    end else if (hotTrip) begin
      mTherm = 1; mOn = 0; mCnt = -1;
    end else if (mTherm) begin
      if (coolOk) begin
        mTherm = 0;
        mOn = enIn && !uvFlag && !ovFlag;
        mCnt = -1;
      end
    end else if (!enIn || uvFlag) begin
      mOn = 0; mCnt = -1; mOvMem = 0;
    end else if (mOn) begin
      if (ovFlag) begin mOn = 0; mOvMem = 1; end
    end else if (mCnt < 0) begin
      if (mOvMem) begin
        if (ovClrFlag && !ovFlag) begin mCnt = 0; mNeed = S * D; end
      end else if (!ovFlag) begin
        mCnt = 0; mNeed = L * D;
      end
    end else begin
      if (ovFlag) begin mOvMem = 1; mCnt = -1; end
      else if (mOvMem && !ovClrFlag) mCnt = -1;
      else if (mCnt == mNeed) begin mOn = 1; mCnt = -1; end
      else mCnt = mCnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (gateOn !== mOn) begin
        failures++;
        $display("FAIL %s gateOn actual=%0b expected=%0b t=%0t", curReq, gateOn, mOn, $time);
      end
      checks++;
      if (ackOut !== gateOn) begin // R8
        failures++;
        $display("FAIL R8 ackOut actual=%0b expected=%0b t=%0t", ackOut, gateOn, $time);
      end
    end
  end

  task automatic setIn(input bit e, input bit u, input bit o, input bit oc,
                       input bit tr, input bit co);
    @(negedge clk);
    enIn = e; uvFlag = u; ovFlag = o; ovClrFlag = oc; hotTrip = tr; coolOk = co;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    curReq = "R1";
    waitc(4);
    setIn(0, 1, 0, 1, 0, 1);
    rst = 1'b0;
    waitc(3);
    curReq = "R2";
    setIn(1, 0, 0, 1, 0, 1);
    waitc(200);
    curReq = "R3";
    setIn(1, 1, 0, 1, 0, 1); waitc(5);
    curReq = "R5";
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    curReq = "R3";
    setIn(1, 0, 1, 0, 0, 1); waitc(5);
    curReq = "R4";
    setIn(1, 0, 0, 0, 0, 1); waitc(30);
    setIn(1, 0, 0, 1, 0, 1); waitc(120);
    curReq = "R9";
    setIn(1, 0, 1, 0, 0, 1); waitc(3);
    setIn(1, 0, 0, 1, 0, 1); waitc(79);
    setIn(1, 0, 0, 0, 0, 1);
    setIn(1, 0, 0, 1, 0, 1); waitc(120);
    setIn(1, 1, 0, 1, 0, 1); waitc(2);
    setIn(1, 0, 0, 1, 0, 1); waitc(159);
    setIn(1, 1, 0, 1, 0, 1);
    setIn(1, 0, 0, 1, 0, 1); waitc(100);
    setIn(0, 0, 0, 1, 0, 1);
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    curReq = "R5";
    setIn(1, 0, 1, 0, 0, 1); waitc(3);
    setIn(1, 1, 0, 1, 0, 1); waitc(3);
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    curReq = "R10";
    setIn(0, 0, 0, 1, 0, 1); waitc(5);
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    setIn(1, 0, 1, 0, 0, 1); waitc(3);
    setIn(0, 0, 0, 1, 0, 1); waitc(3);
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    curReq = "R6";
    setIn(1, 0, 0, 1, 1, 0); waitc(10);
    setIn(1, 0, 0, 1, 0, 0); waitc(10);
    curReq = "R7";
    setIn(1, 0, 0, 1, 0, 1); waitc(10);
    setIn(1, 0, 0, 1, 1, 0); waitc(5);
    setIn(1, 1, 0, 1, 1, 0); waitc(3);
    setIn(1, 1, 0, 1, 0, 1); waitc(5);
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    setIn(1, 0, 0, 1, 1, 0); waitc(3);
    setIn(0, 0, 0, 1, 1, 0); waitc(3);
    setIn(0, 0, 0, 1, 0, 1); waitc(5);
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    curReq = "R11";
    setIn(0, 1, 1, 0, 1, 0); waitc(5);
    setIn(0, 1, 1, 0, 0, 1); waitc(5);
    setIn(1, 1, 1, 0, 0, 1); waitc(5);
    setIn(1, 0, 1, 0, 0, 1); waitc(5);
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    curReq = "R1";
    rst = 1'b1; waitc(3);
    rst = 1'b0;
    setIn(1, 0, 0, 1, 0, 1); waitc(200);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule